// File: doc/BRIEF.md
# Postfix Stack Evaluator

This block runs a short program of stack instructions that evaluates an arithmetic expression given in postfix order. It keeps its operands on an internal last-in, first-out store. Only two instructions touch data memory. A load instruction reads a word from memory and places it on the stack. A store instruction writes the top word back to memory and removes it. The two arithmetic instructions carry no address: each takes the two topmost entries and leaves a single result in their place.

After reset, execution begins at instruction slot 0. The block presents a program counter and receives one instruction word per slot. It runs until it meets a stop instruction, then raises `done_o` and stays idle. Data memory is a plain synchronous RAM. Read data returns one cycle after the address is seen. A write takes effect on the clock edge at the end of the cycle in which the write strobe is high. Stack misuse is recorded in two sticky fault flags.

Top module: `stack_expr_engine`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `pc_o` is 0 and `mem_we_o`, `done_o`, `overflow_o` and `underflow_o` are all 0.
- R2: An instruction word is {opcode[10:8], address[7:0]}. Opcode 1 loads the memory word at the address onto the top of the stack.
- R3: Opcode 2 writes the top entry to memory at the address and removes it from the stack. `mem_we_o` is high for exactly one cycle for each such store.
- R4: Opcode 3 replaces the top two entries with their sum, truncated to 16 bits.
- R5: Opcode 4 replaces the top two entries with the low 16 bits of their product.
- R6: Entries leave the stack in the reverse of the order in which they entered it.
- R7: An opcode 3 or 4 with fewer than two entries, or an opcode 2 with an empty stack, sets `underflow_o`. The flag stays set until reset. The stack is left unchanged and no memory write occurs.
- R8: The stack holds 8 entries. A load on a full stack sets `overflow_o`, which stays set until reset, and the load is ignored.
- R9: Opcode 0 raises `done_o`. From then on `pc_o` stays fixed, no memory write occurs, and later instructions are not executed.
- R10: A load takes 3 cycles. Every other instruction, including one that is refused for a fault, takes 1 cycle. `done_o` therefore rises after 3·L + K + 1 clock edges counted from reset release, where L is the number of executed loads and K is the number of other instructions before the stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 5 | Slot index of the instruction being fetched |
| instr_i | input | 11 | Instruction word for slot `pc_o` |
| mem_addr_o | output | 8 | Data memory address (registered) |
| mem_wdata_o | output | 16 | Data memory write word (registered) |
| mem_we_o | output | 1 | Data memory write strobe (registered) |
| mem_rdata_i | input | 16 | Data memory read word, valid one cycle after the address |
| done_o | output | 1 | Program reached a stop instruction |
| overflow_o | output | 1 | Sticky: a load was refused because the stack was full |
| underflow_o | output | 1 | Sticky: an operation needed more entries than were held |

## Verification
A store's data reaches the bench memory on the edge that follows the cycle in which `mem_we_o` is high. That edge is the one on which the next instruction executes, so every stored value is in memory by the time `done_o` is seen. Each program ends with a stop instruction, and the bench reads memory only after it has seen `done_o`. The bench samples all outputs on falling edges. Because of that, the edge count to `done_o` and the number of write-strobe cycles can be compared exactly with the 3·L + K + 1 formula of R10 and with the number of stores. An operand left on the stack is made visible by storing it to a fresh address.

// File: rtl/sx_pkg.sv
package sx_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_HALT = 3'd0,
    OP_LOAD = 3'd1,
    OP_STORE = 3'd2,
    OP_ADD = 3'd3,
    OP_MUL = 3'd4
  } sx_op_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_ADDR,
    ST_CAPT,
    ST_IDLE
  } sx_state_e;
endpackage

// File: rtl/sx_alu.sv
module sx_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_mul,
  output logic [W-1:0] y
);
  logic [2*W-1:0] prod;
  logic [W-1:0]   sum;

  always_comb begin
    prod = a * b;
    sum  = a + b;
    y    = sel_mul ? prod[W-1:0] : sum;
  end
endmodule

// File: rtl/sx_stack.sv
module sx_stack #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push_en,
  input  logic [W-1:0]               push_data,
  input  logic                       pop_en,
  input  logic                       fold_en,
  input  logic [W-1:0]               fold_data,
  output logic [W-1:0]               top,
  output logic [W-1:0]               below,
  output logic [$clog2(DEPTH+1)-1:0] depth,
  output logic                       full,
  output logic                       empty,
  output logic                       two
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]   mem [DEPTH];
  logic [SPW-1:0] sp;
  logic [SPW-1:0] sp_m1;
  logic [SPW-1:0] sp_m2;

  assign sp_m1 = sp - SPW'(1);
  assign sp_m2 = sp - SPW'(2);
  assign top   = mem[sp_m1[IW-1:0]];
  assign below = mem[sp_m2[IW-1:0]];
  assign depth = sp;
  assign full  = (sp == SPW'(DEPTH));
  assign empty = (sp == '0);
  assign two   = (sp >= SPW'(2));

  // Storage has no reset so that it can map to distributed or block RAM.
  always_ff @(posedge clk) begin
    if (push_en) mem[sp[IW-1:0]] <= push_data;
    else if (fold_en) mem[sp_m2[IW-1:0]] <= fold_data;
  end

  always_ff @(posedge clk) begin
    if (rst) sp <= '0;
    else if (push_en) sp <= sp + SPW'(1);
    else if (pop_en || fold_en) sp <= sp_m1;
  end

  p_depth_bound_r8: assert property (@(posedge clk) disable iff (rst)
    depth <= SPW'(DEPTH));

  p_no_push_full_r8: assert property (@(posedge clk) disable iff (rst)
    push_en |-> !full);

  p_depth_step_r6: assert property (@(posedge clk) disable iff (rst)
    (depth == $past(depth)) || (depth == $past(depth) + SPW'(1)) ||
    (depth + SPW'(1) == $past(depth)));
endmodule

// File: rtl/stack_expr_engine.sv
module stack_expr_engine #(
  parameter int W     = 16,
  parameter int AW    = 8,
  parameter int PC_W  = 5,
  parameter int DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  output logic [PC_W-1:0]           pc_o,
  input  logic [sx_pkg::OP_W+AW-1:0] instr_i,
  output logic [AW-1:0]             mem_addr_o,
  output logic [W-1:0]              mem_wdata_o,
  output logic                      mem_we_o,
  input  logic [W-1:0]              mem_rdata_i,
  output logic                      done_o,
  output logic                      overflow_o,
  output logic                      underflow_o
);
  import sx_pkg::*;

  localparam int SPW = $clog2(DEPTH + 1);

  sx_state_e      state;
  sx_op_e         op;
  logic [AW-1:0]  arg;
  logic [W-1:0]   top, below, alu_y;
  logic [SPW-1:0] depth;
  logic           full, empty, two;
  logic           push_en, pop_en, fold_en, is_bin;

  assign op     = sx_op_e'(instr_i[OP_W+AW-1:AW]);
  assign arg    = instr_i[AW-1:0];
  assign is_bin = (op == OP_ADD) || (op == OP_MUL);

  assign push_en = (state == ST_CAPT);
  assign pop_en  = (state == ST_RUN) && (op == OP_STORE) && !empty;
  assign fold_en = (state == ST_RUN) && is_bin && two;

  sx_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst),
    .push_en(push_en), .push_data(mem_rdata_i),
    .pop_en(pop_en), .fold_en(fold_en), .fold_data(alu_y),
    .top(top), .below(below), .depth(depth),
    .full(full), .empty(empty), .two(two)
  );

  sx_alu #(.W(W)) u_alu (
    .a(below), .b(top), .sel_mul(op == OP_MUL), .y(alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_RUN;
      pc_o        <= '0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      mem_we_o    <= 1'b0;
      done_o      <= 1'b0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      mem_we_o <= 1'b0;
      unique case (state)
        ST_RUN: begin
          case (op)
            OP_HALT: begin
              done_o <= 1'b1;
              state  <= ST_IDLE;
            end
            OP_LOAD: begin
              if (full) begin
                overflow_o <= 1'b1;
                pc_o       <= pc_o + PC_W'(1);
              end else begin
                mem_addr_o <= arg;
                state      <= ST_ADDR;
              end
            end
            OP_STORE: begin
              if (empty) underflow_o <= 1'b1;
              else begin
                mem_addr_o  <= arg;
                mem_wdata_o <= top;
                mem_we_o    <= 1'b1;
              end
              pc_o <= pc_o + PC_W'(1);
            end
            OP_ADD, OP_MUL: begin
              if (!two) underflow_o <= 1'b1;
              pc_o <= pc_o + PC_W'(1);
            end
            default: pc_o <= pc_o + PC_W'(1);
          endcase
        end
        ST_ADDR: state <= ST_CAPT;
        ST_CAPT: begin
          pc_o  <= pc_o + PC_W'(1);
          state <= ST_RUN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && !mem_we_o && !done_o && !overflow_o && !underflow_o));

  p_halt_freezes_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (done_o && !mem_we_o && $stable(pc_o)));

  p_unf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    underflow_o |=> underflow_o);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overflow_o |=> overflow_o);

  p_store_pops_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> ($past(depth) == depth + SPW'(1)));
endmodule

// File: tb/sim_stack_expr_engine.sv
`timescale 1ns/1ps
module sim_stack_expr_engine;
  localparam logic [2:0] C_HALT = 3'd0, C_LOAD = 3'd1, C_STORE = 3'd2,
                         C_ADD = 3'd3, C_MUL = 3'd4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  pc;
  logic [10:0] instr;
  logic [7:0]  maddr;
  logic [15:0] mwdata, mrdata;
  logic        mwe, done, ovf, unf;

  logic [10:0] imem [32];
  logic [15:0] dmem [256];
  logic        tb_we = 1'b0;
  logic [7:0]  tb_a = '0;
  logic [15:0] tb_d = '0;
  int          plen = 0;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  assign instr = imem[pc];

  always @(posedge clk) begin
    if (tb_we) dmem[tb_a] <= tb_d;
    else if (mwe) dmem[maddr] <= mwdata;
    mrdata <= dmem[maddr];
  end

  stack_expr_engine u0 (
    .clk(clk), .rst(rst), .pc_o(pc), .instr_i(instr),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_we_o(mwe),
    .mem_rdata_i(mrdata), .done_o(done), .overflow_o(ovf), .underflow_o(unf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    tb_a = a; tb_d = d; tb_we = 1'b1;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) imem[i] = '0;
    plen = 0;
  endtask

  task automatic emit(input logic [2:0] op, input logic [7:0] a);
    imem[plen] = {op, a};
    plen++;
  endtask

  task automatic run_prog(output int cyc, output int wes);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc = 0; wes = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (mwe) wes++;
      if (done) break;
    end
    if (!done) check("watchdog", 32'(done), 32'd1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 pc", 32'(pc), 0);
    check("R1 flags", {28'd0, mwe, done, ovf, unf}, 0);
    clear_prog();
    emit(C_LOAD, 8'd1);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 pc after release", 32'(pc), 0);
    check("R1 flags after release", {28'd0, mwe, done, ovf, unf}, 0);
  endtask

  task automatic t_three_addr();
    int c, w;
    poke(10, 3); poke(11, 5); poke(12, 7); poke(13, 2); poke(20, 0);
    clear_prog();
    emit(C_LOAD, 10); emit(C_LOAD, 11); emit(C_ADD, 0);
    emit(C_LOAD, 12); emit(C_LOAD, 13); emit(C_ADD, 0);
    emit(C_MUL, 0); emit(C_STORE, 20); emit(C_HALT, 0);
    run_prog(c, w);
    check("R2 R4 R5 (A+B)(C+D)", 32'(dmem[20]), 72);
    check("R10 cycles expr1", c, 17);
    check("R3 one strobe", w, 1);
    check("R7 R8 no faults", {30'd0, ovf, unf}, 0);
  endtask

  task automatic t_postfix();
    int c, w;
    poke(30, 2); poke(31, 3); poke(32, 4); poke(33, 5); poke(34, 6);
    clear_prog();
    emit(C_LOAD, 30); emit(C_LOAD, 31); emit(C_ADD, 0); emit(C_LOAD, 32);
    emit(C_MUL, 0); emit(C_LOAD, 33); emit(C_LOAD, 34); emit(C_MUL, 0);
    emit(C_ADD, 0); emit(C_STORE, 40); emit(C_HALT, 0);
    run_prog(c, w);
    check("R4 R5 postfix result", 32'(dmem[40]), 50);
    check("R10 cycles postfix", c, 21);
  endtask

  task automatic t_lifo();
    int c, w;
    poke(50, 16'h0111); poke(51, 16'h0222); poke(52, 16'h0333); poke(63, 16'hBEEF);
    clear_prog();
    emit(C_LOAD, 50); emit(C_LOAD, 51); emit(C_LOAD, 52);
    emit(C_STORE, 60); emit(C_STORE, 61); emit(C_STORE, 62);
    emit(C_STORE, 63); emit(C_HALT, 0);
    run_prog(c, w);
    check("R6 first out", 32'(dmem[60]), 32'h0333);
    check("R6 second out", 32'(dmem[61]), 32'h0222);
    check("R6 third out", 32'(dmem[62]), 32'h0111);
    check("R7 empty store no write", 32'(dmem[63]), 32'hBEEF);
    check("R7 underflow set", 32'(unf), 1);
    check("R3 strobe count", w, 3);
    check("R10 cycles lifo", c, 14);
  endtask

  task automatic t_wrap();
    int c, w;
    poke(1, 16'hFFFF); poke(2, 16'h0002); poke(3, 16'h1234); poke(4, 16'h0100);
    clear_prog();
    emit(C_LOAD, 1); emit(C_LOAD, 2); emit(C_ADD, 0); emit(C_STORE, 5);
    emit(C_LOAD, 3); emit(C_LOAD, 4); emit(C_MUL, 0); emit(C_STORE, 6);
    emit(C_HALT, 0);
    run_prog(c, w);
    check("R4 sum truncation", 32'(dmem[5]), 32'h0001);
    check("R5 product truncation", 32'(dmem[6]), 32'h3400);
  endtask

  task automatic t_underflow();
    int c, w;
    poke(70, 16'h0042); poke(71, 0); poke(72, 16'hAAAA);
    clear_prog();
    emit(C_ADD, 0); emit(C_LOAD, 70); emit(C_MUL, 0);
    emit(C_STORE, 71); emit(C_STORE, 72); emit(C_HALT, 0);
    run_prog(c, w);
    check("R7 stack kept after refused ops", 32'(dmem[71]), 32'h0042);
    check("R7 refused store no write", 32'(dmem[72]), 32'hAAAA);
    check("R7 flags", {30'd0, ovf, unf}, 1);
    check("R3 R7 strobe count", w, 1);
    check("R10 cycles underflow", c, 8);
  endtask

  task automatic t_overflow();
    int c, w;
    for (int i = 0; i < 9; i++) poke(8'(80 + i), 16'(16'h0100 + i));
    for (int i = 0; i < 8; i++) poke(8'(100 + i), 16'hDEAD);
    clear_prog();
    for (int i = 0; i < 9; i++) emit(C_LOAD, 8'(80 + i));
    for (int i = 0; i < 8; i++) emit(C_STORE, 8'(100 + i));
    emit(C_HALT, 0);
    run_prog(c, w);
    for (int j = 0; j < 8; j++)
      check("R8 R6 kept entries", 32'(dmem[100 + j]), 32'(16'h0100 + 7 - j));
    check("R8 flags", {30'd0, ovf, unf}, 2);
    check("R10 cycles overflow", c, 34);
  endtask

  task automatic t_halt();
    int c, w;
    logic [4:0] pc_at;
    poke(90, 16'h5555); poke(91, 16'h7777);
    clear_prog();
    emit(C_LOAD, 90); emit(C_HALT, 0); emit(C_STORE, 91); emit(C_HALT, 0);
    run_prog(c, w);
    pc_at = pc;
    w = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (mwe) w++;
    end
    check("R9 pc frozen", 32'(pc), 32'(pc_at));
    check("R9 no strobe", w, 0);
    check("R9 later store skipped", 32'(dmem[91]), 32'h7777);
    check("R9 done held", 32'(done), 1);
    check("R10 cycles halt", c, 4);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) dmem[i] = '0;
    clear_prog();
    t_reset();
    t_three_addr();
    t_postfix();
    t_lifo();
    t_wrap();
    t_underflow();
    t_overflow();
    t_halt();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule